// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets a processor core reach external memory and I/O devices through a narrow, time-shared pin set. The core issues single-byte read and write requests with a 16-bit address. The block turns each request into one fixed-length bus cycle. The upper address byte goes out on a dedicated port. The lower address byte and the data byte share a single 8-bit port and are separated in time by an address latch enable strobe (ALE). An external latch is expected to catch the low address on the falling edge of ALE. Active-low write and read strobes then frame the data phase.

A single mode bit selects the pin function. While the bit is clear, the same pins act as plain parallel ports and are driven from the core's port registers. While the bit is set, the pins act as the bus. A bus cycle that is already running always completes before the pins return to port use.

The core sees a busy flag and a one-cycle done pulse. Read data is valid with the done pulse.

Top module: `xbus_master`

## Requirements
- R1: After reset, the mode bit is clear, busy and done are low, ALE is low, both strobes are high, and the shared port is not driven when the port-mode direction input is low.
- R2: A cycle with `mode_we` high loads `mode_wdata` into the mode bit on the next clock edge, and `bus_mode` shows the stored value.
- R3: While the mode bit is clear and no cycle is running: the pins follow the port inputs (`pin_hi`=`pio_hi_o`, `pin_lo_o`=`pio_lo_o`, `pin_lo_oe`=`pio_lo_oe`); ALE stays low and both strobes stay high; `pio_lo_i` mirrors `pin_lo_i`; requests are ignored, so busy and done stay low.
- R4: A request taken while idle in bus mode starts a cycle on the next edge. The cycle keeps busy high for exactly 6 clocks, and done is high only in the 6th clock.
- R5: `pin_hi` carries address bits 15:8 in all 6 clocks of a cycle and keeps that value while the bus is idle.
- R6: ALE is high in clocks 1–2 and low from clock 3. In clocks 1–3 the shared port is driven with address bits 7:0, so the low byte is valid at the falling edge of ALE.
- R7: On a write, `wr_n` is low in clocks 4–5 only. The data byte is driven on the shared port from clock 4 through clock 6, so it is valid when `wr_n` rises.
- R8: On a read, the shared port is released from clock 4 on, and `rd_n` is low in clocks 4–5. `pin_lo_i` is sampled at the clock edge that ends clock 5, and that byte appears on `rd_data` while done is high.
- R9: `wr_n` and `rd_n` are never low together, and neither is low while ALE is high.
- R10: Requests that arrive while busy are ignored. After a cycle ends there is one idle clock, and then a held request starts an identical new cycle.
- R11: In bus mode while idle, ALE is low, both strobes are high, and the shared port is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write enable for the mode bit |
| mode_wdata | input | 1 | New mode bit value (1 = bus, 0 = ports) |
| bus_mode | output | 1 | Current mode bit |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data byte |
| busy | output | 1 | Bus cycle running |
| done | output | 1 | One-cycle pulse in the last clock of a cycle |
| rd_data | output | 8 | Byte captured by the last read |
| pio_hi_o | input | 8 | Port-mode value for the high pins |
| pio_lo_o | input | 8 | Port-mode value for the shared pins |
| pio_lo_oe | input | 1 | Port-mode direction of the shared pins |
| pio_lo_i | output | 8 | Shared pin input returned to the core |
| pin_hi | output | 8 | High address pins |
| pin_lo_o | output | 8 | Shared pin output value |
| pin_lo_oe | output | 1 | Shared pin output enable |
| pin_lo_i | input | 8 | Shared pin input value |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
A request seen at a clock edge in idle bus mode changes the pins in the cycle after that edge. From there, ALE, the strobes and the shared-port enable follow a fixed six-clock timetable counted from that edge. The bench keeps this timetable as a phase counter in its own model. The model advances on the rising edge with the same inputs the design sees, and every output is compared at the following falling edge. `rd_data` is compared only when the model expects done. A mode write takes effect one edge later, and so only requests after that edge are accepted. The external device in the bench drives the true read byte only in the single clock before the capture edge, so a capture one edge early or late returns the wrong value.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed bus master.
// Assumes: phases are visited strictly in the listed order.
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,   // ALE high, low address on shared port
        PH_HOLD = 3'd2,   // ALE low, low address still driven
        PH_STB  = 3'd3,   // write or read strobe low
        PH_TAIL = 3'd4    // strobes high, data hold, done
    } phase_e;

endpackage

// File: rtl/xbus_mode_reg.sv
// Mode bit register: selects parallel-port use (0) or bus use (1).
// Assumes: written only through the single-bit write port.
module xbus_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic wdata,
    output logic mode
);

    // Hold the mode bit; reset returns the pins to port use.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= 1'b0;
        else if (we)
            mode <= wdata;
    end

endmodule

// File: rtl/xbus_seq.sv
// Bus cycle sequencer: walks address, hold, strobe and tail phases for
// one byte transfer and produces the bus-side pin values.
// Assumes: every phase length parameter is at least 1.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int ADDR_CYC = 2,
    parameter int HOLD_CYC = 1,
    parameter int STB_CYC  = 2,
    parameter int TAIL_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    lo_in,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic             ale,
    output logic             wr_n,
    output logic             rd_n,
    output logic [AW-DW-1:0] hi_out,
    output logic [DW-1:0]    lo_out,
    output logic             lo_oe
);

    localparam int HW   = AW - DW;
    localparam int M1   = (ADDR_CYC > HOLD_CYC) ? ADDR_CYC : HOLD_CYC;
    localparam int M2   = (STB_CYC > TAIL_CYC) ? STB_CYC : TAIL_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    phase_e          state;
    phase_e          nxt_state;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   len_m1;
    logic            last;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q;
    logic            wr_q;
    logic [DW-1:0]   rd_q;
    logic            start;

    assign start = (state == PH_IDLE) && req_valid && enable;

    // Pick the length and successor of the current phase.
    always_comb begin
        len_m1    = '0;
        nxt_state = PH_IDLE;
        case (state)
            PH_ADDR: begin len_m1 = CW'(ADDR_CYC - 1); nxt_state = PH_HOLD; end
            PH_HOLD: begin len_m1 = CW'(HOLD_CYC - 1); nxt_state = PH_STB;  end
            PH_STB:  begin len_m1 = CW'(STB_CYC - 1);  nxt_state = PH_TAIL; end
            PH_TAIL: begin len_m1 = CW'(TAIL_CYC - 1); nxt_state = PH_IDLE; end
            default: begin len_m1 = '0;                nxt_state = PH_IDLE; end
        endcase
    end

    assign last = (cnt == len_m1);

    // Advance the phase and its clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else if (state == PH_IDLE) begin
            cnt <= '0;
            if (start)
                state <= PH_ADDR;
        end else if (last) begin
            state <= nxt_state;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Latch the request when a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            wr_q   <= 1'b0;
        end else if (start) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            wr_q   <= req_write;
        end
    end

    // Capture read data on the edge that ends the strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (state == PH_STB && last && !wr_q)
            rd_q <= lo_in;
    end

    // Decode pin values and handshake from the phase.
    always_comb begin
        ale    = (state == PH_ADDR);
        wr_n   = !((state == PH_STB) && wr_q);
        rd_n   = !((state == PH_STB) && !wr_q);
        hi_out = addr_q[AW-1 -: HW];
        lo_out = ((state == PH_ADDR) || (state == PH_HOLD)) ? addr_q[DW-1:0] : data_q;
        lo_oe  = (state == PH_ADDR) || (state == PH_HOLD) ||
                 (wr_q && ((state == PH_STB) || (state == PH_TAIL)));
        busy   = (state != PH_IDLE);
        done   = (state == PH_TAIL) && last;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/xbus_pinmux.sv
// Pin multiplexer: hands the pins to the bus sequencer or to the
// core's parallel-port registers.
// Assumes: bus_sel stays high for the whole of a running cycle.
module xbus_pinmux #(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic          bus_sel,
    input  logic          b_ale,
    input  logic          b_wr_n,
    input  logic          b_rd_n,
    input  logic [HW-1:0] b_hi,
    input  logic [DW-1:0] b_lo,
    input  logic          b_oe,
    input  logic [HW-1:0] p_hi,
    input  logic [DW-1:0] p_lo,
    input  logic          p_oe,
    output logic [HW-1:0] pin_hi,
    output logic [DW-1:0] pin_lo_o,
    output logic          pin_lo_oe,
    output logic          ale,
    output logic          wr_n,
    output logic          rd_n
);

    // Route either owner to the pins; strobes idle in port use.
    always_comb begin
        if (bus_sel) begin
            pin_hi    = b_hi;
            pin_lo_o  = b_lo;
            pin_lo_oe = b_oe;
            ale       = b_ale;
            wr_n      = b_wr_n;
            rd_n      = b_rd_n;
        end else begin
            pin_hi    = p_hi;
            pin_lo_o  = p_lo;
            pin_lo_oe = p_oe;
            ale       = 1'b0;
            wr_n      = 1'b1;
            rd_n      = 1'b1;
        end
    end

endmodule

// File: rtl/xbus_master.sv
// Multiplexed address/data bus master top level.
// Assumes: the core holds req_* stable while req_valid is high and idle.
module xbus_master #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic             mode_wdata,
    output logic             bus_mode,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    input  logic [AW-DW-1:0] pio_hi_o,
    input  logic [DW-1:0]    pio_lo_o,
    input  logic             pio_lo_oe,
    output logic [DW-1:0]    pio_lo_i,
    output logic [AW-DW-1:0] pin_hi,
    output logic [DW-1:0]    pin_lo_o,
    output logic             pin_lo_oe,
    input  logic [DW-1:0]    pin_lo_i,
    output logic             ale,
    output logic             wr_n,
    output logic             rd_n
);

    localparam int HW = AW - DW;

    logic          mode;
    logic          s_ale;
    logic          s_wr_n;
    logic          s_rd_n;
    logic [HW-1:0] s_hi;
    logic [DW-1:0] s_lo;
    logic          s_oe;

    xbus_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode)
    );

    xbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lo_in     (pin_lo_i),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .ale       (s_ale),
        .wr_n      (s_wr_n),
        .rd_n      (s_rd_n),
        .hi_out    (s_hi),
        .lo_out    (s_lo),
        .lo_oe     (s_oe)
    );

    xbus_pinmux #(.DW(DW), .HW(HW)) u_mux (
        .bus_sel   (mode | busy),
        .b_ale     (s_ale),
        .b_wr_n    (s_wr_n),
        .b_rd_n    (s_rd_n),
        .b_hi      (s_hi),
        .b_lo      (s_lo),
        .b_oe      (s_oe),
        .p_hi      (pio_hi_o),
        .p_lo      (pio_lo_o),
        .p_oe      (pio_lo_oe),
        .pin_hi    (pin_hi),
        .pin_lo_o  (pin_lo_o),
        .pin_lo_oe (pin_lo_oe),
        .ale       (ale),
        .wr_n      (wr_n),
        .rd_n      (rd_n)
    );

    assign bus_mode = mode;
    assign pio_lo_i = pin_lo_i;

endmodule

// File: rtl/xbus_master_chk.sv
// Protocol checker for xbus_master, attached by bind.
// Assumes: sampled on the rising clock edge, synchronous active-low reset.
module xbus_master_chk #(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_mode,
    input logic          busy,
    input logic          done,
    input logic          ale,
    input logic          wr_n,
    input logic          rd_n,
    input logic [HW-1:0] pin_hi,
    input logic [DW-1:0] pin_lo_o,
    input logic          pin_lo_oe
);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    // R9
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (wr_n && rd_n));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R5
    hi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pin_hi));

    // R6
    ale_fall_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (pin_lo_oe && $stable(pin_lo_o)));

    // R7
    wr_rise_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (pin_lo_oe && $stable(pin_lo_o)));

    // R8
    rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !pin_lo_oe);

    // R3
    port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mode && !busy) |-> (!ale && wr_n && rd_n));

endmodule

bind xbus_master xbus_master_chk #(.DW(DW), .HW(AW - DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_mode  (bus_mode),
    .busy      (busy),
    .done      (done),
    .ale       (ale),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .pin_hi    (pin_hi),
    .pin_lo_o  (pin_lo_o),
    .pin_lo_oe (pin_lo_oe)
);

// File: tb/xbus_master_test.sv
`timescale 1ns/1ps
module xbus_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic        mode_wdata = 1'b0;
    logic        bus_mode;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic        done;
    logic [7:0]  rd_data;
    logic [7:0]  pio_hi_o = '0;
    logic [7:0]  pio_lo_o = '0;
    logic        pio_lo_oe = 1'b0;
    logic [7:0]  pio_lo_i;
    logic [7:0]  pin_hi;
    logic [7:0]  pin_lo_o;
    logic        pin_lo_oe;
    logic [7:0]  pin_lo_i = '0;
    logic        ale;
    logic        wr_n;
    logic        rd_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model state
    int          ph = -1;
    bit          m_mode = 0;
    bit          m_wr = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic [7:0]  ext_val = 8'h3C;

    always #4 clk = ~clk;

    xbus_master uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .bus_mode(bus_mode), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .pio_hi_o(pio_hi_o), .pio_lo_o(pio_lo_o),
        .pio_lo_oe(pio_lo_oe), .pio_lo_i(pio_lo_i), .pin_hi(pin_hi),
        .pin_lo_o(pin_lo_o), .pin_lo_oe(pin_lo_oe), .pin_lo_i(pin_lo_i),
        .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Model: advance the six-clock timetable on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ph = -1; m_mode = 0; m_addr = '0; m_data = '0; m_wr = 0;
        end else begin
            if (ph == -1) begin
                if (req_valid && m_mode) begin
                    ph = 0; m_addr = req_addr; m_data = req_wdata; m_wr = req_write;
                end
            end else if (ph == 5) ph = -1;
            else ph++;
            if (mode_we) m_mode = mode_wdata;
        end
    end

    // External device: true read byte only in the clock before capture.
    always @(negedge clk) pin_lo_i = (ph == 4) ? ext_val : ~ext_val;

    // Compare every output against the model at the falling edge.
    always @(negedge clk) begin
        if (rst_n && cyc > 6) begin
            bit bus_sel;
            bus_sel = m_mode || (ph != -1);
            chk(bus_mode == m_mode, "R2 bus_mode", 16'(bus_mode), 16'(m_mode));
            chk(busy == (ph != -1), "R4/R10 busy", 16'(busy), 16'(ph != -1));
            chk(done == (ph == 5), "R4 done", 16'(done), 16'(ph == 5));
            chk(pio_lo_i == pin_lo_i, "R3 pio_lo_i", 16'(pio_lo_i), 16'(pin_lo_i));
            if (!bus_sel) begin
                chk(!ale && wr_n && rd_n, "R3 strobes", {13'd0, ale, wr_n, rd_n}, 16'h3);
                chk(pin_hi == pio_hi_o, "R3 pin_hi", 16'(pin_hi), 16'(pio_hi_o));
                chk(pin_lo_oe == pio_lo_oe, "R3 oe", 16'(pin_lo_oe), 16'(pio_lo_oe));
                chk(pin_lo_o == pio_lo_o, "R3 pin_lo", 16'(pin_lo_o), 16'(pio_lo_o));
            end else if (ph == -1) begin
                chk(!ale && wr_n && rd_n, "R11 strobes", {13'd0, ale, wr_n, rd_n}, 16'h3);
                chk(!pin_lo_oe, "R11 oe", 16'(pin_lo_oe), 16'h0);
                chk(pin_hi == m_addr[15:8], "R5 idle hi", 16'(pin_hi), 16'(m_addr[15:8]));
            end else begin
                logic e_ale, e_wr, e_rd, e_oe;
                logic [7:0] e_lo;
                e_ale = (ph <= 1);
                e_wr  = !(m_wr && (ph == 3 || ph == 4));
                e_rd  = !(!m_wr && (ph == 3 || ph == 4));
                e_oe  = (ph <= 2) || m_wr;
                e_lo  = (ph <= 2) ? m_addr[7:0] : m_data;
                chk(pin_hi == m_addr[15:8], "R5 hi", 16'(pin_hi), 16'(m_addr[15:8]));
                chk(ale == e_ale, "R6 ale", 16'(ale), 16'(e_ale));
                chk(wr_n == e_wr, "R7 wr_n", 16'(wr_n), 16'(e_wr));
                chk(rd_n == e_rd, "R8 rd_n", 16'(rd_n), 16'(e_rd));
                chk(pin_lo_oe == e_oe, "R6/R8 oe", 16'(pin_lo_oe), 16'(e_oe));
                if (e_oe)
                    chk(pin_lo_o == e_lo, "R6/R7 lo", 16'(pin_lo_o), 16'(e_lo));
                chk(!(!wr_n && !rd_n) && !(ale && !(wr_n && rd_n)), "R9 exclusive",
                    {13'd0, ale, wr_n, rd_n}, {13'd0, e_ale, e_wr, e_rd});
                if (ph == 5 && !m_wr)
                    chk(rd_data == ext_val, "R8 rd_data", 16'(rd_data), 16'(ext_val));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic one_req(input bit w, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(bus_mode == 0, "R1 mode", 16'(bus_mode), 16'h0);
        chk(!busy && !done, "R1 busy/done", {14'd0, busy, done}, 16'h0);
        chk(!ale && wr_n && rd_n, "R1 strobes", {13'd0, ale, wr_n, rd_n}, 16'h3);
        chk(!pin_lo_oe, "R1 oe", 16'(pin_lo_oe), 16'h0);
        repeat (2) @(negedge clk);

        // R3: port mode, requests ignored
        pio_hi_o = 8'h5A; pio_lo_o = 8'hC3; pio_lo_oe = 1;
        req_valid = 1; req_write = 1; req_addr = 16'h7777; req_wdata = 8'h11;
        repeat (8) @(negedge clk);
        chk(!busy, "R3 request ignored", 16'(busy), 16'h0);
        req_valid = 0; pio_lo_oe = 0;

        // R2: enter bus mode
        mode_we = 1; mode_wdata = 1;
        @(negedge clk);
        mode_we = 0;
        chk(bus_mode == 1, "R2 set", 16'(bus_mode), 16'h1);
        repeat (2) @(negedge clk);

        // R5 R6 R7: two identical writes
        one_req(1, 16'h1234, 8'hA5);
        one_req(1, 16'h1234, 8'hA5);

        // R10: held request with changes while busy
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h00FF; req_wdata = 8'h5E;
        @(negedge clk);
        req_addr = 16'h5555; req_wdata = 8'h77;
        repeat (10) @(negedge clk);
        req_valid = 0;
        repeat (8) @(negedge clk);

        // R8: reads
        ext_val = 8'h3C; one_req(0, 16'hBEEF, 8'h00);
        ext_val = 8'h00; one_req(0, 16'h0001, 8'hFF);
        ext_val = 8'hFF; one_req(0, 16'hFF80, 8'h00);

        // R3/R4: mode cleared mid-cycle, cycle still completes
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h8001; req_wdata = 8'h3B;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        mode_we = 1; mode_wdata = 0;
        @(negedge clk);
        mode_we = 0;
        chk(busy == 1, "R4 cycle continues", 16'(busy), 16'h1);
        pio_lo_oe = 1; pio_lo_o = 8'h96;
        repeat (8) @(negedge clk);
        chk(pin_lo_o == 8'h96 && pin_lo_oe, "R3 back to port", 16'(pin_lo_o), 16'h96);
        finish_run();
    end

endmodule